// File: doc/BRIEF.md
# Packed Colour Lookup Table with Component Expansion

This block holds the colour lookup table of a display pipeline. The table has 256 colour entries of 16 bits each, kept two per 32-bit word in a register window that a bus master writes and reads. Each entry packs three 5-bit colour fields and one intensity bit. The bus side treats every word as raw data. What is written there is returned unchanged on a read.

The pixel side takes an 8-bit colour index. One clock later it returns the entry as three 8-bit channels. Each 5-bit field is widened by appending three zero bits. The intensity bit takes no part in the output. A swap input exchanges the red and blue channels, so that panels with either channel order can be served. Fetching the frame buffer and unpacking pixels from memory are left to neighbouring blocks.

Top module: `clut_packed`

## Requirements
- R1: The window covers byte offsets 0x200 through 0x3FF. A bus write there stores all 32 bits of `bus_wdata` in word (offset − 0x200) >> 2. The two low offset bits are ignored.
- R2: A bus read inside the window returns the stored word in the same cycle, bit for bit as written, including bits 15 and 31.
- R3: A bus write outside the window changes no stored word. A bus read outside the window returns zero.
- R4: Colour index i selects word i >> 1. When bit 0 of i is 0 the lower halfword (bits 15:0) is used; when it is 1 the upper halfword (bits 31:16) is used.
- R5: Within the selected halfword, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. Each channel output is its 5-bit field shifted left by 3, so the three low output bits are zero.
- R6: Bit 15 of the selected halfword (the intensity bit) has no effect on any channel output.
- R7: When `swap_rb` is high together with a valid index, the red output carries the field from bits 14:10 and the blue output carries the field from bits 4:0. Green is unchanged.
- R8: `rgb_valid` is high exactly one cycle after `pix_valid` was high. The colour outputs keep their value in every cycle that follows a cycle without `pix_valid`.
- R9: If a bus write and a lookup address the same word in the same cycle, the lookup returns the contents that word held before the write.
- R10: After reset every stored word reads as zero, `rgb_valid` is low and all channel outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pix_valid | input | 1 | Colour index is valid |
| pix_index | input | 8 | Colour index |
| swap_rb | input | 1 | Exchange the red and blue outputs |
| rgb_valid | output | 1 | Colour outputs belong to a new lookup |
| rgb_r | output | 8 | Red channel |
| rgb_g | output | 8 | Green channel |
| rgb_b | output | 8 | Blue channel |

## Verification
The bench builds the block with its default parameters: 128 words based at offset 0x200 in a 12-bit address space. At that size every word can be written and read back, and all 256 indices can be looked up with the swap both off and on. Words are filled from an arithmetic pattern that sets bits 15 and 31 on many entries, and the bench computes each expected channel from the stored word.

The small address space also puts the edges of the window within reach: 0x1FC and 0x400 on either side of it, offset 0 and the top offset 0xFFC. A same-cycle write and lookup on one word is covered, as is a pair of words that differ only in their intensity bits.

// File: rtl/clut_pkg.sv
// Package clut_pkg
// Shared widths and the layout of one packed colour entry.
// Assumes three equal-width colour fields below a single intensity bit.
package clut_pkg;
    localparam int CLUT_CH_W  = 5;
    localparam int CLUT_OUT_W = 8;

    // One halfword without its intensity bit, most significant field first.
    typedef struct packed {
        logic [CLUT_CH_W-1:0] blu;
        logic [CLUT_CH_W-1:0] grn;
        logic [CLUT_CH_W-1:0] red;
    } clut_entry_t;
endpackage

// File: rtl/clut_decode.sv
// Module clut_decode
// Decodes a byte offset into a window hit and a word number.
// Assumes BASE is word aligned and the window fits in the address space.
module clut_decode #(
    parameter int ADDR_W = 12,
    parameter int BASE   = 'h200,
    parameter int WORDS  = 128,
    localparam int WA_W  = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [WA_W-1:0]   word
);
    localparam logic [ADDR_W-1:0] LO   = ADDR_W'(BASE);
    localparam logic [ADDR_W:0]   SPAN = (ADDR_W+1)'(WORDS * 4);

    logic [ADDR_W-1:0] rel;

    // Offset relative to the window base, then range test and word pick.
    always_comb begin
        rel  = addr - LO;
        hit  = (addr >= LO) && ({1'b0, rel} < SPAN);
        word = WA_W'(rel >> 2);
    end
endmodule

// File: rtl/clut_store.sv
// Module clut_store
// Word storage of the table with one write port and two read paths:
// a combinational bus read and a registered halfword lookup.
// Assumes a write and a lookup on the same word see the old contents.
module clut_store
    import clut_pkg::*;
#(
    parameter int WORDS = 128,
    localparam int WA_W = $clog2(WORDS),
    localparam int IX_W = WA_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WA_W-1:0]  wr_word,
    input  logic [31:0]      wr_data,
    input  logic [WA_W-1:0]  rd_word,
    output logic [31:0]      rd_data,
    input  logic             lk_valid,
    input  logic [IX_W-1:0]  lk_index,
    input  logic             lk_swap,
    output logic             lk_valid_q,
    output logic             lk_swap_q,
    output clut_entry_t      lk_entry_q
);
    logic [31:0]     mem [WORDS];
    logic [WA_W-1:0] lk_word;
    clut_entry_t     lk_entry_d;

    // Pick the addressed halfword of the lookup word, intensity bit dropped.
    always_comb begin
        lk_word = lk_index[IX_W-1:1];
        if (lk_index[0]) begin
            lk_entry_d = clut_entry_t'(mem[lk_word][30:16]);
        end else begin
            lk_entry_d = clut_entry_t'(mem[lk_word][14:0]);
        end
    end

    // Bus read path is combinational from the word number.
    always_comb begin
        rd_data = mem[rd_word];
    end

    // Storage: clear on reset, otherwise accept one whole-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_word] <= wr_data;
        end
    end

    // Lookup register: capture entry and swap only on a valid index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_valid_q <= 1'b0;
            lk_swap_q  <= 1'b0;
            lk_entry_q <= '0;
        end else begin
            lk_valid_q <= lk_valid;
            if (lk_valid) begin
                lk_swap_q  <= lk_swap;
                lk_entry_q <= lk_entry_d;
            end
        end
    end

    // Same-cycle write and lookup of one word: the captured entry is the old one.
    p_old_on_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && wr_en && (wr_word == lk_word))
        |=> (lk_entry_q == $past(lk_entry_d)));
endmodule

// File: rtl/clut_expand.sv
// Module clut_expand
// Widens each colour field by appending zero bits and optionally
// exchanges the red and blue channels.
// Assumes OUT_W is at least the field width.
module clut_expand
    import clut_pkg::*;
#(
    parameter int OUT_W = CLUT_OUT_W,
    localparam int PAD  = OUT_W - CLUT_CH_W
) (
    input  clut_entry_t      entry,
    input  logic             swap,
    output logic [OUT_W-1:0] r_out,
    output logic [OUT_W-1:0] g_out,
    output logic [OUT_W-1:0] b_out
);
    logic [OUT_W-1:0] r_wide;
    logic [OUT_W-1:0] g_wide;
    logic [OUT_W-1:0] b_wide;

    // Left-justify each field and route red/blue by the swap flag.
    always_comb begin
        r_wide = {entry.red, {PAD{1'b0}}};
        g_wide = {entry.grn, {PAD{1'b0}}};
        b_wide = {entry.blu, {PAD{1'b0}}};
        g_out  = g_wide;
        if (swap) begin
            r_out = b_wide;
            b_out = r_wide;
        end else begin
            r_out = r_wide;
            b_out = b_wide;
        end
    end

    // The padding bits below each field stay zero.
    always_comb begin
        p_low_zero_r5: assert (r_out[PAD-1:0] == '0 && g_out[PAD-1:0] == '0
                               && b_out[PAD-1:0] == '0);
    end
endmodule

// File: rtl/clut_packed.sv
// Module clut_packed
// Colour lookup table: a bus-visible window of packed words and a pixel
// port that returns expanded RGB one cycle after the index.
// Assumes single-cycle bus accesses with combinational read data.
module clut_packed
    import clut_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BASE   = 'h200,
    parameter int WORDS  = 128,
    localparam int WA_W  = $clog2(WORDS),
    localparam int IX_W  = WA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              pix_valid,
    input  logic [IX_W-1:0]   pix_index,
    input  logic              swap_rb,
    output logic              rgb_valid,
    output logic [7:0]        rgb_r,
    output logic [7:0]        rgb_g,
    output logic [7:0]        rgb_b
);
    logic            win_hit;
    logic [WA_W-1:0] win_word;
    logic [31:0]     word_data;
    logic            wr_en;
    logic            swap_q;
    clut_entry_t     entry_q;

    clut_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS)) decode_i (
        .addr (bus_addr),
        .hit  (win_hit),
        .word (win_word)
    );

    // Only in-window write strobes reach the storage.
    always_comb begin
        wr_en     = bus_en && bus_we && win_hit;
        bus_rdata = win_hit ? word_data : 32'h0;
    end

    clut_store #(.WORDS(WORDS)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_word    (win_word),
        .wr_data    (bus_wdata),
        .rd_word    (win_word),
        .rd_data    (word_data),
        .lk_valid   (pix_valid),
        .lk_index   (pix_index),
        .lk_swap    (swap_rb),
        .lk_valid_q (rgb_valid),
        .lk_swap_q  (swap_q),
        .lk_entry_q (entry_q)
    );

    clut_expand #(.OUT_W(8)) expand_i (
        .entry (entry_q),
        .swap  (swap_q),
        .r_out (rgb_r),
        .g_out (rgb_g),
        .b_out (rgb_b)
    );

    // Valid follows the index strobe by exactly one cycle.
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rgb_valid == $past(pix_valid));

    // With no new index the colour outputs keep their value.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> ($stable(rgb_r) && $stable(rgb_g) && $stable(rgb_b)));

    // An in-window write is visible at the same address in the next cycle.
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && win_hit)
        |=> ($stable(bus_addr) |-> (bus_rdata == $past(bus_wdata))));

    // Reads outside the window return zero.
    p_outside_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> (bus_rdata == 32'h0));
endmodule

// File: tb/clut_packed_tb.sv
module clut_packed_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_index = '0;
    logic        swap_rb = 1'b0;
    logic        rgb_valid;
    logic [7:0]  rgb_r, rgb_g, rgb_b;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [128];

    always #2 clk = ~clk;

    clut_packed dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_valid(pix_valid), .pix_index(pix_index), .swap_rb(swap_rb),
        .rgb_valid(rgb_valid), .rgb_r(rgb_r), .rgb_g(rgb_g), .rgb_b(rgb_b)
    );

    function automatic logic [31:0] pattern(int i);
        return (32'(i) * 32'h9E37_79B1) + 32'h1234_5678;
    endfunction

    function automatic logic [23:0] expect_rgb(logic [31:0] w, logic upper, logic sw);
        logic [15:0] hw;
        logic [7:0]  r, g, b;
        hw = upper ? w[31:16] : w[15:0];
        r  = {hw[4:0], 3'b000};
        g  = {hw[9:5], 3'b000};
        b  = {hw[14:10], 3'b000};
        return sw ? {b, g, r} : {r, g, b};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic lookup(logic [7:0] idx, logic sw, output logic [23:0] rgb);
        @(negedge clk);
        pix_valid = 1'b1; pix_index = idx; swap_rb = sw;
        @(negedge clk);
        pix_valid = 1'b0;
        check("R8 valid", 32'(rgb_valid), 32'h1);
        rgb = {rgb_r, rgb_g, rgb_b};
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        logic [23:0] rgb, rgb2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        @(negedge clk);
        check("R10 valid", 32'(rgb_valid), 32'h0);
        check("R10 rgb", {8'h0, rgb_r, rgb_g, rgb_b}, 32'h0);
        bus_read(12'h200, rd); check("R10 word0", rd, 32'h0);
        bus_read(12'h3FC, rd); check("R10 word127", rd, 32'h0);

        // R1, R2: fill every word and read each back raw
        for (int i = 0; i < 128; i++) begin
            model[i] = pattern(i);
            bus_write(12'h200 + 12'(i * 4), model[i]);
        end
        for (int i = 0; i < 128; i++) begin
            bus_read(12'h200 + 12'(i * 4), rd);
            check("R2 readback", rd, model[i]);
        end
        // R1: low offset bits ignored
        bus_read(12'h206, rd); check("R1 low bits", rd, model[1]);
        bus_write(12'h20B, 32'hCAFE_F00D); model[2] = 32'hCAFE_F00D;
        bus_read(12'h208, rd); check("R1 low bits write", rd, model[2]);

        // R3: outside writes ignored, outside reads zero
        bus_write(12'h1FC, 32'hFFFF_FFFF);
        bus_write(12'h400, 32'hFFFF_FFFF);
        bus_write(12'h000, 32'hFFFF_FFFF);
        bus_write(12'hFFC, 32'hFFFF_FFFF);
        bus_read(12'h1FC, rd); check("R3 below", rd, 32'h0);
        bus_read(12'h400, rd); check("R3 above", rd, 32'h0);
        bus_read(12'hFFC, rd); check("R3 top", rd, 32'h0);
        for (int i = 0; i < 128; i++) begin
            bus_read(12'h200 + 12'(i * 4), rd);
            check("R3 untouched", rd, model[i]);
        end

        // R4, R5, R7: every index, swap off and on
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 256; i++) begin
                lookup(8'(i), s[0], rgb);
                check(s ? "R7 swap lookup" : "R4 R5 lookup", 32'(rgb),
                      32'(expect_rgb(model[i >> 1], i[0], s[0])));
            end
        end

        // R8: outputs hold while no index is presented
        lookup(8'd7, 1'b0, rgb);
        @(negedge clk);
        check("R8 drop", 32'(rgb_valid), 32'h0);
        bus_write(12'h20C, 32'h0);
        @(negedge clk);
        check("R8 hold", 32'({rgb_r, rgb_g, rgb_b}), 32'(rgb));
        model[3] = 32'h0;

        // R6: intensity bits change nothing
        bus_write(12'h214, 32'h1234_5678 & 32'h7FFF_7FFF);
        lookup(8'd10, 1'b0, rgb);
        lookup(8'd11, 1'b0, rgb2);
        bus_write(12'h214, 32'h9234_D678);
        model[5] = 32'h9234_D678;
        lookup(8'd10, 1'b0, rd[23:0]);
        check("R6 lower", 32'(rd[23:0]), 32'(rgb));
        lookup(8'd11, 1'b0, rd[23:0]);
        check("R6 upper", 32'(rd[23:0]), 32'(rgb2));

        // R9: write and lookup on the same word in one cycle
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 12'h228; bus_wdata = 32'h7C1F_03E0;
        pix_valid = 1'b1; pix_index = 8'd20; swap_rb = 1'b0;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; pix_valid = 1'b0;
        check("R9 old", 32'({rgb_r, rgb_g, rgb_b}), 32'(expect_rgb(model[10], 1'b0, 1'b0)));
        model[10] = 32'h7C1F_03E0;
        lookup(8'd20, 1'b0, rgb);
        check("R9 new", 32'(rgb), 32'(expect_rgb(model[10], 1'b0, 1'b0)));

        // R10: reset again clears the table
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R10 reset valid", 32'(rgb_valid), 32'h0);
        check("R10 reset rgb", 32'({rgb_r, rgb_g, rgb_b}), 32'h0);
        bus_read(12'h228, rd); check("R10 reset word", rd, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule